// File: doc/BRIEF.md
# Four-Master Shared Bus Fabric with Slot Decode

This block lets four bus masters reach three slaves over one shared bus. The masters use a classic cycle/strobe/acknowledge handshake. Masters that raise their cycle signal take turns through a rotating-priority arbiter. The master that wins keeps the bus until it drops its cycle signal. Its address, write data, byte selects, write flag, cycle and strobe drive a single set of shared outputs that every slave sees.

The two most significant address bits give a slot number. Slaves sit in slots 0, 1 and 3, and slot 2 is a hole. Each slave's cycle and strobe are the shared qualifiers ANDed with that slave's slot match, so at most one slave sees an active transfer. The matching slave's read data and acknowledge go back to the masters. The acknowledge reaches only the master that holds the bus. An access to the hole reaches no slave and gets no acknowledge, so the requesting master waits until it gives up by dropping its cycle signal.

Top module: `shared_bus_fabric`

## Requirements
- R1: After reset, no slave cycle or strobe is asserted and no master acknowledge is asserted.
- R2: When the bus is free, the first master with its cycle signal high wins. The search starts at the master after the last one granted and wraps from master 3 to master 0. The first grant after reset searches from master 0.
- R3: While the granted master keeps its cycle signal high, the grant does not move, even when other masters are requesting.
- R4: The shared address, write data, byte-select and write-flag outputs carry the values of the granted master.
- R5: With AW address bits, bits [AW-1:AW-2] pick the slave: 2'b00 selects slave 0, 2'b01 selects slave 1 and 2'b11 selects slave 2. Only the selected slave's cycle and strobe bits are asserted.
- R6: When the slot bits are 2'b10, no slave cycle or strobe bit is asserted and no master is acknowledged. The master stays waiting until it drops its cycle signal.
- R7: The master read-data output carries the read data of the slave selected by the current address.
- R8: A slave acknowledge reaches only the granted master, and all other master acknowledge bits stay low.
- R9: A request on an idle bus appears on the selected slave's cycle and strobe after one clock edge. When the owner drops its cycle signal, a waiting master is granted at that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| m_cyc | input | NM | Cycle request, one bit per master |
| m_stb | input | NM | Transfer strobe, one bit per master |
| m_we | input | NM | Write flag, one bit per master |
| m_adr | input | NM*AW | Master addresses, master i at bits [i*AW +: AW] |
| m_dat_w | input | NM*DW | Master write data, master i at bits [i*DW +: DW] |
| m_sel | input | NM*DW/8 | Master byte selects |
| m_dat_r | output | DW | Read data returned to the masters |
| m_ack | output | NM | Acknowledge, one bit per master |
| s_cyc | output | NS | Gated cycle, one bit per slave |
| s_stb | output | NS | Gated strobe, one bit per slave |
| s_we | output | 1 | Shared write flag |
| s_adr | output | AW | Shared address |
| s_dat_w | output | DW | Shared write data |
| s_sel | output | DW/8 | Shared byte selects |
| s_dat_r | input | NS*DW | Slave read data, slave i at bits [i*DW +: DW] |
| s_ack | input | NS | Slave acknowledge, one bit per slave |

## Verification
The assertions assume that every master holds its address, strobe and cycle signal steady from request until it sees its acknowledge. They also assume that a master drops its cycle signal for at least one clock edge between transfers, and that a slave acknowledges only while its own gated cycle is high. The bench's masters follow these rules. A master keeps its request until its acknowledge is sampled and releases one time unit after the falling edge where the acknowledge is seen. The one exception is the deliberate abort of a request to the unmapped slot. The bench's slaves answer after a fixed number of wait states and only while their gated cycle and strobe are high.

// File: rtl/shared_bus_fabric.sv
module shared_bus_fabric #(
  parameter int AW = 16,
  parameter int DW = 32,
  parameter int NM = 4,
  parameter int NS = 3,
  parameter logic [2*NS-1:0] SLOT_MAP = 6'b11_01_00
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NM-1:0]    m_cyc,
  input  logic [NM-1:0]    m_stb,
  input  logic [NM-1:0]    m_we,
  input  logic [NM*AW-1:0] m_adr,
  input  logic [NM*DW-1:0] m_dat_w,
  input  logic [NM*DW/8-1:0] m_sel,
  output logic [DW-1:0]    m_dat_r,
  output logic [NM-1:0]    m_ack,
  output logic [NS-1:0]    s_cyc,
  output logic [NS-1:0]    s_stb,
  output logic             s_we,
  output logic [AW-1:0]    s_adr,
  output logic [DW-1:0]    s_dat_w,
  output logic [DW/8-1:0]  s_sel,
  input  logic [NS*DW-1:0] s_dat_r,
  input  logic [NS-1:0]    s_ack
);
  localparam int SW = DW / 8;
  localparam int IW = (NM > 1) ? $clog2(NM) : 1;

  logic [IW-1:0] owner, next_owner;
  logic          locked, found;
  logic          bus_cyc, bus_stb, sel_ack;
  logic [1:0]    slot;
  logic [NS-1:0] hit;

  always_comb begin
    found = 1'b0;
    next_owner = owner;
    for (int k = 1; k <= NM; k++) begin
      int c;
      c = (int'(owner) + k) % NM;
      if (!found && m_cyc[c]) begin
        found = 1'b1;
        next_owner = IW'(c);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      owner  <= IW'(NM - 1);
      locked <= 1'b0;
    end else if (!(locked && m_cyc[owner])) begin
      locked <= found;
      if (found) owner <= next_owner;
    end
  end

  assign bus_cyc = locked & m_cyc[owner];
  assign bus_stb = bus_cyc & m_stb[owner];
  assign s_we    = m_we[owner];
  assign s_adr   = m_adr[int'(owner)*AW +: AW];
  assign s_dat_w = m_dat_w[int'(owner)*DW +: DW];
  assign s_sel   = m_sel[int'(owner)*SW +: SW];
  assign slot    = s_adr[AW-1 -: 2];

  for (genvar i = 0; i < NS; i++) begin : g_slave
    assign hit[i]   = (slot == SLOT_MAP[2*i +: 2]);
    assign s_cyc[i] = bus_cyc & hit[i];
    assign s_stb[i] = bus_stb & hit[i];
  end

  always_comb begin
    m_dat_r = '0;
    sel_ack = 1'b0;
    for (int i = 0; i < NS; i++) begin
      if (hit[i]) m_dat_r = s_dat_r[i*DW +: DW];
      sel_ack = sel_ack | (s_ack[i] & s_cyc[i]);
    end
  end

  always_comb begin
    m_ack = '0;
    m_ack[owner] = sel_ack;
  end
endmodule

module shared_bus_fabric_chk #(
  parameter int AW = 16,
  parameter int NM = 4,
  parameter int NS = 3
) (
  input logic          clk,
  input logic          rst,
  input logic [NM-1:0] m_cyc,
  input logic [NM-1:0] m_ack,
  input logic [NS-1:0] s_cyc,
  input logic [NS-1:0] s_ack,
  input logic [AW-1:0] s_adr
);
  assert_one_slave_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(s_cyc));

  assert_hole_silent_R6: assert property (@(posedge clk) disable iff (rst)
    (s_cyc != '0) |-> (s_adr[AW-1 -: 2] != 2'b10));

  assert_ack_single_R8: assert property (@(posedge clk) disable iff (rst)
    $onehot0(m_ack));

  assert_ack_to_requester_R8: assert property (@(posedge clk) disable iff (rst)
    (m_ack & ~m_cyc) == '0);

  assert_ack_has_source_R6: assert property (@(posedge clk) disable iff (rst)
    (m_ack != '0) |-> ((s_ack & s_cyc) != '0));

  assert_owner_held_R3: assert property (@(posedge clk) disable iff (rst)
    ((s_cyc != '0) && (m_ack == '0)) |=> $stable(s_adr));
endmodule

bind shared_bus_fabric shared_bus_fabric_chk #(.AW(AW), .NM(NM), .NS(NS)) u_chk (
  .clk(clk), .rst(rst), .m_cyc(m_cyc), .m_ack(m_ack),
  .s_cyc(s_cyc), .s_ack(s_ack), .s_adr(s_adr)
);

// File: tb/shared_bus_fabric_bench.sv
module shared_bus_fabric_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int NM = 4;
  localparam int NS = 3;
  localparam int SW = DW / 8;
  localparam int WAIT = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NM-1:0] m_cyc = '0, m_stb = '0, m_we = '0;
  logic [NM*AW-1:0] m_adr = '0;
  logic [NM*DW-1:0] m_dat_w = '0;
  logic [NM*SW-1:0] m_sel = '0;
  logic [DW-1:0] m_dat_r;
  logic [NM-1:0] m_ack;
  logic [NS-1:0] s_cyc, s_stb;
  logic s_we;
  logic [AW-1:0] s_adr;
  logic [DW-1:0] s_dat_w;
  logic [SW-1:0] s_sel;
  logic [NS*DW-1:0] s_dat_r;
  logic [NS-1:0] s_ack = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  shared_bus_fabric #(.AW(AW), .DW(DW), .NM(NM), .NS(NS)) u_shared_bus_fabric (
    .clk(clk), .rst(rst), .m_cyc(m_cyc), .m_stb(m_stb), .m_we(m_we),
    .m_adr(m_adr), .m_dat_w(m_dat_w), .m_sel(m_sel), .m_dat_r(m_dat_r),
    .m_ack(m_ack), .s_cyc(s_cyc), .s_stb(s_stb), .s_we(s_we), .s_adr(s_adr),
    .s_dat_w(s_dat_w), .s_sel(s_sel), .s_dat_r(s_dat_r), .s_ack(s_ack)
  );

  typedef struct {
    int mst; bit we; logic [AW-1:0] adr; logic [DW-1:0] dat; logic [SW-1:0] sel; int slv;
  } exp_t;
  exp_t exp_q[$];
  exp_t mon_e;
  int checks = 0, fails = 0, last_m = 3;
  bit finished = 1'b0;

  int cnt [NS];
  logic [AW-1:0] wr_adr [NS];
  logic [DW-1:0] wr_dat [NS];
  logic [SW-1:0] wr_sel [NS];

  for (genvar gi = 0; gi < NS; gi++) begin : g_rd
    assign s_dat_r[gi*DW +: DW] = {8'(gi + 1), 8'h5A, s_adr};
  end

  always @(posedge clk) begin
    for (int i = 0; i < NS; i++) begin
      if (rst) begin
        s_ack[i] <= 1'b0; cnt[i] <= 0;
      end else if (s_cyc[i] && s_stb[i] && !s_ack[i]) begin
        if (cnt[i] == WAIT) begin
          s_ack[i] <= 1'b1; cnt[i] <= 0;
          if (s_we) begin wr_adr[i] <= s_adr; wr_dat[i] <= s_dat_w; wr_sel[i] <= s_sel; end
        end else cnt[i] <= cnt[i] + 1;
      end else begin
        s_ack[i] <= 1'b0; cnt[i] <= 0;
      end
    end
  end

  function automatic int slv_of(logic [AW-1:0] a);
    case (a[AW-1 -: 2])
      2'b00: return 0;
      2'b01: return 1;
      2'b11: return 2;
      default: return -1;
    endcase
  endfunction

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic push(int m, bit we, logic [AW-1:0] a, logic [DW-1:0] d, logic [SW-1:0] s);
    exp_t e;
    e.mst = m; e.we = we; e.adr = a; e.dat = d; e.sel = s; e.slv = slv_of(a);
    exp_q.push_back(e);
  endtask

  task automatic drive(int m, bit we, logic [AW-1:0] a, logic [DW-1:0] d, logic [SW-1:0] s);
    m_we[m] = we; m_adr[m*AW +: AW] = a; m_dat_w[m*DW +: DW] = d; m_sel[m*SW +: SW] = s;
    m_cyc[m] = 1'b1; m_stb[m] = 1'b1;
  endtask

  task automatic release_m(int m);
    m_cyc[m] = 1'b0; m_stb[m] = 1'b0;
  endtask

  task automatic master_op(int m, bit we, logic [AW-1:0] a, logic [DW-1:0] d, logic [SW-1:0] s);
    drive(m, we, a, d, s);
    do @(negedge clk); while (!m_ack[m]);
    #1 release_m(m);
    @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (!rst && !finished) begin
      if ((s_cyc != '0) && (exp_q.size() > 0))
        chk(s_adr == exp_q[0].adr, "R3 shared bus held by owner", 64'(s_adr), 64'(exp_q[0].adr));
      if (m_ack != '0) begin
        if (exp_q.size() == 0) chk(1'b0, "R8 unexpected acknowledge", 64'(m_ack), 64'd0);
        else begin
          mon_e = exp_q.pop_front();
          chk(m_ack == NM'(1 << mon_e.mst), "R2 R8 acknowledge to granted master",
              64'(m_ack), 64'(1 << mon_e.mst));
          chk(s_ack[mon_e.slv] && s_cyc == NS'(1 << mon_e.slv), "R5 decoded slave",
              64'(s_cyc), 64'(1 << mon_e.slv));
          if (!mon_e.we)
            chk(m_dat_r == {8'(mon_e.slv + 1), 8'h5A, mon_e.adr}, "R7 read data",
                64'(m_dat_r), 64'({8'(mon_e.slv + 1), 8'h5A, mon_e.adr}));
          else
            chk({wr_adr[mon_e.slv], wr_dat[mon_e.slv], wr_sel[mon_e.slv]} ==
                {mon_e.adr, mon_e.dat, mon_e.sel}, "R4 write reaches slave",
                64'(wr_dat[mon_e.slv]), 64'(mon_e.dat));
          last_m = mon_e.mst;
        end
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    checks++; fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_run();
  end

  logic [AW-1:0] cadr [NM];
  initial begin
    cadr[0] = 16'h0100; cadr[1] = 16'h4204; cadr[2] = 16'hC308; cadr[3] = 16'h040C;

    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(s_cyc == '0 && s_stb == '0 && m_ack == '0, "R1 idle in reset", 64'(s_cyc), 64'd0);
    rst = 1'b0;
    @(negedge clk);
    chk(s_cyc == '0 && s_stb == '0 && m_ack == '0, "R1 idle after reset", 64'(s_cyc), 64'd0);

    push(2, 1'b0, 16'h0123, '0, 4'hF);
    fork
      master_op(2, 1'b0, 16'h0123, '0, 4'hF);
      begin
        @(negedge clk);
        chk(s_cyc == 3'b001 && s_stb == 3'b001, "R9 one-edge grant", 64'(s_cyc), 64'h1);
        chk(s_adr == 16'h0123 && !s_we, "R4 address of owner", 64'(s_adr), 64'h0123);
      end
    join

    push(0, 1'b1, 16'h0040, 32'hDEAD0001, 4'b0101);
    master_op(0, 1'b1, 16'h0040, 32'hDEAD0001, 4'b0101);
    push(1, 1'b1, 16'h4044, 32'hBEEF0002, 4'b1100);
    master_op(1, 1'b1, 16'h4044, 32'hBEEF0002, 4'b1100);
    push(3, 1'b1, 16'hC048, 32'hCAFE0003, 4'b0011);
    master_op(3, 1'b1, 16'hC048, 32'hCAFE0003, 4'b0011);
    push(1, 1'b0, 16'h7FFE, '0, 4'hF);
    master_op(1, 1'b0, 16'h7FFE, '0, 4'hF);
    push(2, 1'b0, 16'hFFFF, '0, 4'hF);
    master_op(2, 1'b0, 16'hFFFF, '0, 4'hF);

    // R2: all four request together; rotation starts after the last owner
    for (int k = 1; k <= NM; k++) begin
      int m;
      m = (last_m + k) % NM;
      push(m, 1'b0, cadr[m], '0, 4'hF);
    end
    fork
      master_op(0, 1'b0, cadr[0], '0, 4'hF);
      master_op(1, 1'b0, cadr[1], '0, 4'hF);
      master_op(2, 1'b0, cadr[2], '0, 4'hF);
      master_op(3, 1'b0, cadr[3], '0, 4'hF);
    join

    // R3: master 1 asks while master 0 owns the bus
    push(0, 1'b1, 16'h0200, 32'h11112222, 4'hF);
    push(1, 1'b0, 16'h4210, '0, 4'hF);
    fork
      master_op(0, 1'b1, 16'h0200, 32'h11112222, 4'hF);
      begin @(negedge clk); master_op(1, 1'b0, 16'h4210, '0, 4'hF); end
    join

    push(3, 1'b0, 16'hC000, '0, 4'hF);
    master_op(3, 1'b0, 16'hC000, '0, 4'hF);
    push(3, 1'b1, 16'h0004, 32'h33334444, 4'b1000);
    master_op(3, 1'b1, 16'h0004, 32'h33334444, 4'b1000);

    // R6: master 0 targets the unmapped slot while master 2 waits
    push(2, 1'b0, 16'h0ABC, '0, 4'hF);
    fork
      begin
        drive(0, 1'b0, 16'h8010, '0, 4'hF);
        for (int n = 0; n < 12; n++) begin
          @(negedge clk);
          chk(m_ack == '0 && s_cyc == '0 && s_stb == '0, "R6 unmapped slot stalls",
              64'({m_ack, s_cyc}), 64'd0);
        end
        #1 release_m(0);
      end
      begin @(negedge clk); master_op(2, 1'b0, 16'h0ABC, '0, 4'hF); end
    join

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R2 every request served", 64'(exp_q.size()), 64'd0);
    finish_run();
  end
endmodule